// File: doc/BRIEF.md
# Half-Word Split Sequencer for 32-bit Masters on 16-bit Slaves

This block lets a 32-bit bus master finish an access to a slave that can only move 16 bits per cycle. The master starts the cycle as if the slave were 32 bits wide. On the first rising bus clock edge after the master raises START, the sequencer looks at the two width responses from the slave. If the slave reports a 16-bit width and does not report a 32-bit width, the sequencer takes the cycle over and runs it as two half-word command cycles. It then returns the bus to the master.

The sequencer owns only the control lines. These are the command strobe, a second START pulse and the byte enables for the upper half-word. It also sends a set of strobes to a separate data steering buffer, which handles the lane swaps. Its last action is the EX32 handback that tells the master it may take the bus again. Address decode, arbitration and the data lanes are all outside the block. All signal levels in this description are logical: 1 means asserted.

Top module: `halfword_split_seq`

## Requirements
- R1: While reset is held, every output enable (`cmdOe`, `startOe`, `beOe`, `ex32Oe`) is 0, every driven level is 0, and every buffer strobe is 0. This holds even when reset arrives partway through a sequence.
- R2: The sequencer takes over only at a rising edge where `mstStart`=1, `ex16In`=1 and `ex32In`=0. Any other combination at that edge leaves all outputs at 0 in the following clock.
- R3: In the clock after the takeover edge, which is the clock in which the master drops START, `cmdOut`=1 and `cmdOe`=1.
- R4: Each command phase lasts 1 clock, plus 1 more clock for every rising edge during that phase at which `exRdy`=0.
- R5: Between the two command phases, the sequencer drives `startOut`=1 for exactly one clock with `cmdOut`=0. In that clock it also drives `beOut`=4'b1100, where bit i enables byte lane i. In the next clock it drives `startOut`=0 and `cmdOut`=1, with START and the byte enables still driven.
- R6: On a read, `bufLatchLow` pulses for one clock starting at the edge where each command phase ends. `bufSwapUp` pulses only together with the second of these pulses.
- R7: On a read, `bufDriveWide` and `bufSwapDown` stay 0 for the whole sequence.
- R8: On a write, `bufDriveWide`=1 throughout the first command phase. `bufSwapDown`=1 for the single START clock before the second phase. `bufLatchLow` and `bufSwapUp` stay 0.
- R9: In the clock after the second command phase ends, `startOe` and `beOe` drop to 0 while `cmdOut`=0. In the clock after that, `ex32Out`=1 and `ex32Oe`=1 for one clock. After that, every output returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mstStart | input | 1 | START level driven by the 32-bit master |
| ex32In | input | 1 | Slave reports 32-bit width |
| ex16In | input | 1 | Slave reports 16-bit width |
| exRdy | input | 1 | Slave ready; 0 stretches the command |
| writeSel | input | 1 | 1 = write, 0 = read, sampled at takeover |
| cmdOut | output | 1 | Command strobe level |
| cmdOe | output | 1 | Command strobe drive enable |
| startOut | output | 1 | START level for the second half-word |
| startOe | output | 1 | START drive enable |
| beOut | output | 4 | Byte enables, bit i = lane i |
| beOe | output | 1 | Byte enable drive enable |
| ex32Out | output | 1 | EX32 level for handback |
| ex32Oe | output | 1 | EX32 drive enable |
| bufLatchLow | output | 1 | Buffer: capture low half-word |
| bufSwapUp | output | 1 | Buffer: copy low lanes to upper lanes |
| bufDriveWide | output | 1 | Buffer: drive latched 32-bit write data |
| bufSwapDown | output | 1 | Buffer: copy upper lanes to low lanes |

## Verification
Every step of the sequence shows up on a port in the very next clock. A state machine that skips a step, or stays in a step too long, therefore produces a wrong command width, a missing or doubled START pulse, or a misplaced buffer strobe. That error appears on the first clock where the expected output pattern differs. The bench compares every output in every clock of each sequence, so a defect is caught within one clock of when it first appears. A wrongly held read/write flag is caught at the buffer strobes of the first phase. A handback that releases the bus too early is caught when START or the byte enables are still driven in the EX32 clock.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD1,
    S_WAIT1,
    S_START2,
    S_CMD2,
    S_WAIT2,
    S_RELEASE,
    S_HANDBACK
  } seqState_t;

  // Strobes from the control FSM to the output/steering register stage
  typedef struct packed {
    logic cmdOn;
    logic cmdEn;
    logic startOn;
    logic startEn;
    logic beEn;
    logic ex32On;
    logic latchLow;
    logic swapUp;
    logic driveWide;
    logic swapDown;
  } seqStrobe_t;

endpackage

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mstStart,
  input  logic       ex32In,
  input  logic       ex16In,
  input  logic       exRdy,
  input  logic       writeSel,
  output seqStrobe_t strobeNext
);

  seqState_t state, nextState;
  logic isWrite;
  logic takeover;
  logic wrNext;
  logic inFirst, inSecond;
  logic firstEnd, secondEnd;

  assign takeover = mstStart && ex16In && !ex32In;
  assign inFirst  = (state == S_CMD1) || (state == S_WAIT1);
  assign inSecond = (state == S_CMD2) || (state == S_WAIT2);

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:     if (takeover) nextState = S_CMD1;
      S_CMD1:     nextState = exRdy ? S_START2 : S_WAIT1;
      S_WAIT1:    if (exRdy) nextState = S_START2;
      S_START2:   nextState = S_CMD2;
      S_CMD2:     nextState = exRdy ? S_RELEASE : S_WAIT2;
      S_WAIT2:    if (exRdy) nextState = S_RELEASE;
      S_RELEASE:  nextState = S_HANDBACK;
      S_HANDBACK: nextState = S_IDLE;
      default:    nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && takeover) isWrite <= writeSel;
    end
  end

  assign wrNext    = (state == S_IDLE) ? writeSel : isWrite;
  assign firstEnd  = inFirst && (nextState == S_START2);
  assign secondEnd = inSecond && (nextState == S_RELEASE);

  always_comb begin
    strobeNext           = '0;
    strobeNext.cmdOn     = (nextState == S_CMD1) || (nextState == S_WAIT1) ||
                           (nextState == S_CMD2) || (nextState == S_WAIT2);
    strobeNext.cmdEn     = (nextState != S_IDLE) && (nextState != S_HANDBACK);
    strobeNext.startOn   = (nextState == S_START2);
    strobeNext.startEn   = (nextState == S_START2) || (nextState == S_CMD2) ||
                           (nextState == S_WAIT2);
    strobeNext.beEn      = strobeNext.startEn;
    strobeNext.ex32On    = (nextState == S_HANDBACK);
    strobeNext.latchLow  = !isWrite && (firstEnd || secondEnd);
    strobeNext.swapUp    = !isWrite && secondEnd;
    strobeNext.driveWide = wrNext && ((nextState == S_CMD1) || (nextState == S_WAIT1));
    strobeNext.swapDown  = isWrite && (nextState == S_START2);
  end

  // R2: no takeover without the 16-bit-only response on a START edge
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !takeover) |=> (state == S_IDLE));

  // R4: slave not ready keeps the first command phase going
  a_r4_wait_first: assert property (@(posedge clk) disable iff (!rstN)
    (inFirst && !exRdy) |=> (state == S_WAIT1));

  // R4: slave not ready keeps the second command phase going
  a_r4_wait_second: assert property (@(posedge clk) disable iff (!rstN)
    (inSecond && !exRdy) |=> (state == S_WAIT2));

  // R5: a second START always follows the first command phase
  a_r5_start_follows: assert property (@(posedge clk) disable iff (!rstN)
    (inFirst && exRdy) |=> (state == S_START2));

  // R9: handback always follows the release clock
  a_r9_handback_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RELEASE) |=> (state == S_HANDBACK));

endmodule

// File: rtl/hws_outreg.sv
module hws_outreg
  import hws_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobeNext,
  output logic             cmdOut,
  output logic             cmdOe,
  output logic             startOut,
  output logic             startOe,
  output logic [LANES-1:0] beOut,
  output logic             beOe,
  output logic             ex32Out,
  output logic             ex32Oe,
  output logic             bufLatchLow,
  output logic             bufSwapUp,
  output logic             bufDriveWide,
  output logic             bufSwapDown
);

  localparam int HALF = LANES / 2;
  localparam logic [LANES-1:0] UPPER_MASK = {{HALF{1'b1}}, {(LANES - HALF){1'b0}}};

  seqStrobe_t strobeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= '0;
    else       strobeQ <= strobeNext;
  end

  assign cmdOut       = strobeQ.cmdOn;
  assign cmdOe        = strobeQ.cmdEn;
  assign startOut     = strobeQ.startOn;
  assign startOe      = strobeQ.startEn;
  assign beOe         = strobeQ.beEn;
  assign beOut        = strobeQ.beEn ? UPPER_MASK : '0;
  assign ex32Out      = strobeQ.ex32On;
  assign ex32Oe       = strobeQ.ex32On;
  assign bufLatchLow  = strobeQ.latchLow;
  assign bufSwapUp    = strobeQ.swapUp;
  assign bufDriveWide = strobeQ.driveWide;
  assign bufSwapDown  = strobeQ.swapDown;

  // R5: the START pulse is followed by a command with START low
  a_r5_start_then_cmd: assert property (@(posedge clk) disable iff (!rstN)
    startOut |=> (cmdOut && !startOut && startOe));

  // R9: START and byte enables are released before EX32 is driven
  a_r9_release_first: assert property (@(posedge clk) disable iff (!rstN)
    ex32Out |-> (!startOe && !beOe && $past(!startOe)));

  // R6: the upper-lane copy comes with the final capture
  a_r6_swap_with_latch: assert property (@(posedge clk) disable iff (!rstN)
    bufSwapUp |-> bufLatchLow);

  // R8: lane swap for writes only during the START pulse
  a_r8_swapdown_start: assert property (@(posedge clk) disable iff (!rstN)
    bufSwapDown |-> (startOut && !bufLatchLow));

  // R3: command strobe is never driven without its enable
  a_r3_cmd_enabled: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut |-> cmdOe);

endmodule

// File: rtl/halfword_split_seq.sv
module halfword_split_seq
  import hws_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mstStart,
  input  logic             ex32In,
  input  logic             ex16In,
  input  logic             exRdy,
  input  logic             writeSel,
  output logic             cmdOut,
  output logic             cmdOe,
  output logic             startOut,
  output logic             startOe,
  output logic [LANES-1:0] beOut,
  output logic             beOe,
  output logic             ex32Out,
  output logic             ex32Oe,
  output logic             bufLatchLow,
  output logic             bufSwapUp,
  output logic             bufDriveWide,
  output logic             bufSwapDown
);

  seqStrobe_t strobeNext;

  hws_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mstStart   (mstStart),
    .ex32In     (ex32In),
    .ex16In     (ex16In),
    .exRdy      (exRdy),
    .writeSel   (writeSel),
    .strobeNext (strobeNext)
  );

  hws_outreg #(.LANES(LANES)) u_outreg (
    .clk          (clk),
    .rstN         (rstN),
    .strobeNext   (strobeNext),
    .cmdOut       (cmdOut),
    .cmdOe        (cmdOe),
    .startOut     (startOut),
    .startOe      (startOe),
    .beOut        (beOut),
    .beOe         (beOe),
    .ex32Out      (ex32Out),
    .ex32Oe       (ex32Oe),
    .bufLatchLow  (bufLatchLow),
    .bufSwapUp    (bufSwapUp),
    .bufDriveWide (bufDriveWide),
    .bufSwapDown  (bufSwapDown)
  );

endmodule

// File: tb/halfword_split_seq_tb.sv
`timescale 1ns/1ps
module halfword_split_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mstStart = 1'b0, ex32In = 1'b0, ex16In = 1'b0, exRdy = 1'b1, writeSel = 1'b0;
  logic cmdOut, cmdOe, startOut, startOe, beOe, ex32Out, ex32Oe;
  logic [3:0] beOut;
  logic bufLatchLow, bufSwapUp, bufDriveWide, bufSwapDown;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  halfword_split_seq u_dut (
    .clk(clk), .rstN(rstN), .mstStart(mstStart), .ex32In(ex32In), .ex16In(ex16In),
    .exRdy(exRdy), .writeSel(writeSel), .cmdOut(cmdOut), .cmdOe(cmdOe),
    .startOut(startOut), .startOe(startOe), .beOut(beOut), .beOe(beOe),
    .ex32Out(ex32Out), .ex32Oe(ex32Oe), .bufLatchLow(bufLatchLow),
    .bufSwapUp(bufSwapUp), .bufDriveWide(bufDriveWide), .bufSwapDown(bufSwapDown)
  );

  // {cmdOe,cmdOut,startOe,startOut,beOe,beOut,ex32Oe,ex32Out,latch,swapUp,wide,swapDown}
  wire [14:0] snap = {cmdOe, cmdOut, startOe, startOut, beOe, beOut, ex32Oe, ex32Out,
                      bufLatchLow, bufSwapUp, bufDriveWide, bufSwapDown};

  function automatic logic [14:0] pat(bit cE, bit c, bit sE, bit s, bit bE, bit x,
                                      bit lat, bit up, bit wide, bit dn);
    return {cE, c, sE, s, bE, (bE ? 4'b1100 : 4'b0000), x, x, lat, up, wide, dn};
  endfunction

  task automatic check(string req, logic [14:0] exp);
    nChecks++;
    if (snap !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, snap, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; mstStart = 1'b0; ex16In = 1'b0; ex32In = 1'b0; exRdy = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs idle in reset", '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs idle after reset", '0);
  endtask

  // Full two half-word sequence; w1/w2 = not-ready clocks per phase
  task automatic runSeq(bit isWr, int w1, int w2);
    @(negedge clk);
    mstStart = 1'b1; ex16In = 1'b1; ex32In = 1'b0; writeSel = isWr;
    @(negedge clk);
    mstStart = 1'b0;
    for (int i = 0; i <= w1; i++) begin
      check(isWr ? "R3 R4 R8 first command (write)" : "R3 R4 R7 first command (read)",
            pat(1, 1, 0, 0, 0, 0, 0, 0, isWr, 0));
      exRdy = (i == w1);
      @(negedge clk);
    end
    check(isWr ? "R5 R8 second START (write)" : "R5 R6 second START (read)",
          pat(1, 0, 1, 1, 1, 0, !isWr, 0, 0, isWr));
    @(negedge clk);
    for (int j = 0; j <= w2; j++) begin
      check("R4 R5 second command", pat(1, 1, 1, 0, 1, 0, 0, 0, 0, 0));
      exRdy = (j == w2);
      @(negedge clk);
    end
    check(isWr ? "R9 R8 release (write)" : "R9 R6 release (read)",
          pat(1, 0, 0, 0, 0, 0, !isWr, !isWr, 0, 0));
    @(negedge clk);
    check("R9 EX32 handback", pat(0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    @(negedge clk);
    check("R9 all released after handback", '0);
    exRdy = 1'b1; ex16In = 1'b0;
  endtask

  task automatic noTakeover(bit st, bit e32, bit e16);
    @(negedge clk);
    mstStart = st; ex32In = e32; ex16In = e16;
    @(negedge clk);
    mstStart = 1'b0;
    check("R2 no takeover", '0);
    @(negedge clk);
    check("R2 still idle", '0);
    ex32In = 1'b0; ex16In = 1'b0;
  endtask

  task automatic resetMidway();
    @(negedge clk);
    mstStart = 1'b1; ex16In = 1'b1; ex32In = 1'b0; writeSel = 1'b0; exRdy = 1'b1;
    @(negedge clk);
    mstStart = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset during sequence", '0);
    @(negedge clk);
    rstN = 1'b1; ex16In = 1'b0;
    @(negedge clk);
    check("R1 idle after mid reset", '0);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    noTakeover(1, 1, 1);     // R2: 32-bit slave answered
    noTakeover(1, 0, 0);     // R2: no width response
    noTakeover(0, 0, 1);     // R2: width response without START
    runSeq(0, 0, 0);         // read, no waits
    runSeq(1, 0, 0);         // write, no waits
    runSeq(0, 2, 1);         // read, stretched phases
    runSeq(1, 1, 3);         // write, stretched phases
    resetMidway();
    runSeq(0, 0, 2);         // read after mid-sequence reset
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule